// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power state a small microcontroller is in and drives the enable lines that make that state real. Software asks for IDLE, STANDBY or SHUTDOWN while the chip is running. The sequencer then spends a short, fixed entry window before the requested mode takes effect. In that window any wake event cancels the entry and the chip returns to running at once.

Each low-power mode listens only to its own wake sources. IDLE accepts an interrupt, an RTC tick or an enabled pin edge. STANDBY accepts an RTC tick or an enabled pin edge. SHUTDOWN accepts only an enabled pin edge. Leaving a mode costs a wake-up delay: 14 µs from IDLE, 151 µs from STANDBY and 1015 µs from SHUTDOWN, counted in reference-clock cycles. A pin wake from SHUTDOWN is handled as a reset of the rest of the chip, not as a resume.

Holding the external reset pin forces every domain off, from any state. Releasing the pin replays the shutdown-length wake-up under reset. A sticky cause field records why the chip last came out of reset.

Top module: `lpm_seq`

## Requirements
- R1: After power-on reset (rst_ni low) the block is running. This means active_o=1, mode_o=0 and rst_cause_o=0, por_en_o=1, and every enable is at its running value: cpu, flash, sram, radio, peripheral, high-speed and low-speed clock all 1, bod_mode_o=2 (continuous), io_latch_o=0 and reg_ret_o=2 (full).
- R2: A request (req_valid_i with req_mode_i encoded 1=IDLE, 2=STANDBY, 3=SHUTDOWN) is accepted only while running. When no wake arrives, the mode takes effect ENTRY_CYCLES clock edges after the accepting edge. A request made in any other state is ignored.
- R3: In IDLE, only the CPU clock is off and reg_ret_o=2. An interrupt, an RTC tick or an enabled pin edge wakes the block, and active_o returns after US_IDLE·REF_CLK_MHZ cycles.
- R4: In STANDBY, only sram_ret_o and lf_clk_en_o stay on. bod_mode_o=1 (duty-cycled), reg_ret_o=1 (partial) and io_latch_o=1. An interrupt is ignored. An RTC tick or an enabled pin edge wakes the block after US_STBY·REF_CLK_MHZ cycles.
- R5: In SHUTDOWN every enable is off, bod_mode_o=0, reg_ret_o=0 and io_latch_o=1. Interrupts and RTC ticks are ignored. An enabled pin edge starts a US_SHUT·REF_CLK_MHZ cycle wake with sys_rst_o=1 and sets rst_cause_o=2.
- R6: While reset_pin_i is high, every enable is 0, sys_rst_o=1 and rst_cause_o=1. After release, sys_rst_o stays 1 and active_o returns after US_SHUT·REF_CLK_MHZ cycles.
- R7: A wake source (interrupt, RTC tick or enabled pin edge) seen during the entry window returns the block to running on the next edge, with no wake latency.
- R8: Once rst_cause_o is non-zero, only a power-on reset clears it to 0.
- R9: A pin edge is a change of pin_i in either direction on a bit whose pin_wake_en_i bit is 1. Changes on other bits have no effect in any state.
- R10: por_en_o is 1 in every state, including reset-pin hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| reset_pin_i | input | 1 | External reset pin held (high) |
| req_valid_i | input | 1 | Software low-power request strobe |
| req_mode_i | input | 2 | Requested mode: 1 IDLE, 2 STANDBY, 3 SHUTDOWN |
| irq_i | input | 1 | Any pending interrupt |
| rtc_tick_i | input | 1 | RTC wake event |
| pin_i | input | NUM_PINS | Wake-capable pin levels |
| pin_wake_en_i | input | NUM_PINS | Per-pin wake enable |
| mode_o | output | 2 | Current low-power mode, 0 when not in one |
| active_o | output | 1 | Block is running |
| sys_rst_o | output | 1 | Reset to the rest of the chip |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_en_o | output | 1 | Flash enable |
| sram_ret_o | output | 1 | SRAM retention enable |
| radio_en_o | output | 1 | Radio enable |
| periph_en_o | output | 1 | Peripheral clock enable |
| hf_clk_en_o | output | 1 | High-speed clock enable |
| lf_clk_en_o | output | 1 | Low-speed clock enable |
| bod_mode_o | output | 2 | Brown-out monitor: 0 off, 1 duty-cycled, 2 continuous |
| por_en_o | output | 1 | Power-on-reset monitor enable |
| io_latch_o | output | 1 | Hold I/O at pre-entry values |
| reg_ret_o | output | 2 | Register retention: 0 none, 1 partial, 2 full |
| rst_cause_o | output | 2 | Reset cause: 0 power-on, 1 reset pin, 2 shutdown pin wake |

## Verification
The bench builds the block with REF_CLK_MHZ=1, ENTRY_CYCLES=3 and four pins, two of them wake-enabled. With that clock rate, every wake latency is the microsecond figure itself. The longest wake is then 1015 cycles, so the bench can count every wake to its exact cycle. Because the configuration is small, the bench sweeps every low-power mode against every wake source: interrupt, RTC tick, enabled pin and masked pin. It sweeps every mode against each aborting source in the entry window. The reset-pin and reset-cause sequences also run to completion.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {M_ACTIVE = 2'd0, M_IDLE = 2'd1, M_STBY = 2'd2, M_SHUT = 2'd3} lpm_mode_e;
  typedef enum logic [2:0] {S_ACTIVE, S_ENTER, S_IDLE, S_STBY, S_SHUT, S_WAKE, S_HOLD} lpm_state_e;
  typedef enum logic [1:0] {BOD_OFF = 2'd0, BOD_DUTY = 2'd1, BOD_CONT = 2'd2} bod_e;
  typedef enum logic [1:0] {RET_NONE = 2'd0, RET_PART = 2'd1, RET_FULL = 2'd2} ret_e;
  typedef enum logic [1:0] {CAUSE_POR = 2'd0, CAUSE_PIN = 2'd1, CAUSE_SHUT = 2'd2} cause_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic sram;
    logic radio;
    logic periph;
    logic hf;
    logic lf;
    bod_e bod;
    logic latch;
    ret_e reg_ret;
  } lpm_en_t;

  localparam int unsigned US_IDLE = 14;
  localparam int unsigned US_STBY = 151;
  localparam int unsigned US_SHUT = 1015;
endpackage

// File: rtl/lpm_down_cnt.sv
module lpm_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  lpm_state_e          state_i,
  input  logic                irq_i,
  input  logic                rtc_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  output logic                wake_o,
  output logic                abort_o
);
  logic [NUM_PINS-1:0] pin_q;
  logic                pedge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  // either polarity counts, masked per pin
  assign pedge = |((pin_i ^ pin_q) & pin_en_i);

  always_comb begin
    unique case (state_i)
      S_IDLE:  wake_o = irq_i | rtc_i | pedge;
      S_STBY:  wake_o = rtc_i | pedge;
      S_SHUT:  wake_o = pedge;
      default: wake_o = 1'b0;
    endcase
  end

  assign abort_o = irq_i | rtc_i | pedge;
endmodule

// File: rtl/lpm_out_map.sv
module lpm_out_map
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  input  logic       latch_hold_i,
  output lpm_en_t    en_o,
  output lpm_mode_e  mode_o
);
  always_comb begin
    en_o   = '0;
    mode_o = M_ACTIVE;
    unique case (state_i)
      S_ACTIVE, S_ENTER: begin
        en_o.cpu     = (state_i == S_ACTIVE);
        en_o.flash   = 1'b1;
        en_o.sram    = 1'b1;
        en_o.radio   = 1'b1;
        en_o.periph  = 1'b1;
        en_o.hf      = 1'b1;
        en_o.lf      = 1'b1;
        en_o.bod     = BOD_CONT;
        en_o.reg_ret = RET_FULL;
      end
      S_IDLE: begin
        mode_o       = M_IDLE;
        en_o.flash   = 1'b1;
        en_o.sram    = 1'b1;
        en_o.radio   = 1'b1;
        en_o.periph  = 1'b1;
        en_o.hf      = 1'b1;
        en_o.lf      = 1'b1;
        en_o.bod     = BOD_CONT;
        en_o.reg_ret = RET_FULL;
      end
      S_STBY: begin
        mode_o       = M_STBY;
        en_o.sram    = 1'b1;
        en_o.lf      = 1'b1;
        en_o.bod     = BOD_DUTY;
        en_o.latch   = 1'b1;
        en_o.reg_ret = RET_PART;
      end
      S_SHUT: begin
        mode_o     = M_SHUT;
        en_o.latch = 1'b1;
      end
      S_WAKE: begin
        en_o.flash   = 1'b1;
        en_o.sram    = 1'b1;
        en_o.hf      = 1'b1;
        en_o.lf      = 1'b1;
        en_o.bod     = BOD_CONT;
        en_o.latch   = latch_hold_i;
        en_o.reg_ret = RET_FULL;
      end
      default: en_o = '0;
    endcase
  end
endmodule

// File: rtl/lpm_rst_cause.sv
module lpm_rst_cause
  import lpm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   set_pin_i,
  input  logic   set_shut_i,
  output cause_e cause_o
);
  cause_e cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cause_q <= CAUSE_POR;
    else if (set_pin_i)  cause_q <= CAUSE_PIN;
    else if (set_shut_i) cause_q <= CAUSE_SHUT;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned REF_CLK_MHZ  = 48,
  parameter int unsigned ENTRY_CYCLES = 4,
  parameter int unsigned NUM_PINS     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reset_pin_i,
  input  logic                req_valid_i,
  input  logic [1:0]          req_mode_i,
  input  logic                irq_i,
  input  logic                rtc_tick_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_wake_en_i,
  output logic [1:0]          mode_o,
  output logic                active_o,
  output logic                sys_rst_o,
  output logic                cpu_clk_en_o,
  output logic                flash_en_o,
  output logic                sram_ret_o,
  output logic                radio_en_o,
  output logic                periph_en_o,
  output logic                hf_clk_en_o,
  output logic                lf_clk_en_o,
  output logic [1:0]          bod_mode_o,
  output logic                por_en_o,
  output logic                io_latch_o,
  output logic [1:0]          reg_ret_o,
  output logic [1:0]          rst_cause_o
);
  localparam int unsigned LAT_IDLE = US_IDLE * REF_CLK_MHZ;
  localparam int unsigned LAT_STBY = US_STBY * REF_CLK_MHZ;
  localparam int unsigned LAT_SHUT = US_SHUT * REF_CLK_MHZ;
  localparam int unsigned CNT_MAX  = (LAT_SHUT > ENTRY_CYCLES) ? LAT_SHUT : ENTRY_CYCLES;
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  lpm_state_e       state_q, state_d;
  lpm_mode_e        tgt_q, tgt_d;
  logic             rst_wake_q, rst_wake_d;
  logic             latch_hold_q, latch_hold_d;
  logic             ld_ent, ld_lat, ent_zero, lat_zero;
  logic [CNT_W-1:0] lat_val;
  logic             wake, abort;
  lpm_en_t          en;
  lpm_mode_e        mode;
  cause_e           cause;

  lpm_wake_qual #(.NUM_PINS(NUM_PINS)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state_q),
    .irq_i    (irq_i),
    .rtc_i    (rtc_tick_i),
    .pin_i    (pin_i),
    .pin_en_i (pin_wake_en_i),
    .wake_o   (wake),
    .abort_o  (abort)
  );

  lpm_down_cnt #(.W(CNT_W)) u_ent_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_ent),
    .load_val_i (CNT_W'(ENTRY_CYCLES - 1)),
    .dec_i      (state_q == S_ENTER),
    .zero_o     (ent_zero)
  );

  lpm_down_cnt #(.W(CNT_W)) u_lat_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_lat),
    .load_val_i (lat_val),
    .dec_i      (state_q == S_WAKE),
    .zero_o     (lat_zero)
  );

  always_comb begin
    state_d      = state_q;
    tgt_d        = tgt_q;
    rst_wake_d   = rst_wake_q;
    latch_hold_d = latch_hold_q;
    ld_ent       = 1'b0;
    ld_lat       = 1'b0;
    lat_val      = '0;
    if (reset_pin_i) begin
      state_d = S_HOLD;
    end else begin
      unique case (state_q)
        S_ACTIVE: if (req_valid_i && req_mode_i != M_ACTIVE) begin
          state_d = S_ENTER;
          tgt_d   = lpm_mode_e'(req_mode_i);
          ld_ent  = 1'b1;
        end
        S_ENTER: begin
          if (abort)         state_d = S_ACTIVE;
          else if (ent_zero) state_d = (tgt_q == M_IDLE) ? S_IDLE :
                                       (tgt_q == M_STBY) ? S_STBY : S_SHUT;
        end
        S_IDLE, S_STBY, S_SHUT: if (wake) begin
          state_d      = S_WAKE;
          ld_lat       = 1'b1;
          rst_wake_d   = (state_q == S_SHUT);
          latch_hold_d = (state_q != S_IDLE);
          lat_val      = (state_q == S_IDLE) ? CNT_W'(LAT_IDLE - 1) :
                         (state_q == S_STBY) ? CNT_W'(LAT_STBY - 1) : CNT_W'(LAT_SHUT - 1);
        end
        S_WAKE: if (lat_zero) begin
          state_d      = S_ACTIVE;
          rst_wake_d   = 1'b0;
          latch_hold_d = 1'b0;
        end
        S_HOLD: begin
          state_d      = S_WAKE;
          ld_lat       = 1'b1;
          lat_val      = CNT_W'(LAT_SHUT - 1);
          rst_wake_d   = 1'b1;
          latch_hold_d = 1'b0;
        end
        default: state_d = S_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_ACTIVE;
      tgt_q        <= M_IDLE;
      rst_wake_q   <= 1'b0;
      latch_hold_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      tgt_q        <= tgt_d;
      rst_wake_q   <= rst_wake_d;
      latch_hold_q <= latch_hold_d;
    end
  end

  lpm_rst_cause u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_pin_i  (reset_pin_i),
    .set_shut_i (state_q == S_SHUT && wake),
    .cause_o    (cause)
  );

  lpm_out_map u_map (
    .state_i      (state_q),
    .latch_hold_i (latch_hold_q),
    .en_o         (en),
    .mode_o       (mode)
  );

  assign mode_o       = mode;
  assign active_o     = (state_q == S_ACTIVE);
  assign sys_rst_o    = (state_q == S_HOLD) || (state_q == S_WAKE && rst_wake_q);
  assign cpu_clk_en_o = en.cpu;
  assign flash_en_o   = en.flash;
  assign sram_ret_o   = en.sram;
  assign radio_en_o   = en.radio;
  assign periph_en_o  = en.periph;
  assign hf_clk_en_o  = en.hf;
  assign lf_clk_en_o  = en.lf;
  assign bod_mode_o   = en.bod;
  assign por_en_o     = 1'b1;
  assign io_latch_o   = en.latch;
  assign reg_ret_o    = en.reg_ret;
  assign rst_cause_o  = cause;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input lpm_state_e          state_q,
  input logic                reset_pin_i,
  input logic                req_valid_i,
  input logic                irq_i,
  input logic                rtc_tick_i,
  input logic [NUM_PINS-1:0] pin_i,
  input logic                active_o,
  input logic                sys_rst_o,
  input logic                cpu_clk_en_o,
  input logic                sram_ret_o,
  input logic [1:0]          rst_cause_o
);
  a_r6_hold_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_pin_i |=> (sys_rst_o && !cpu_clk_en_o && !sram_ret_o && rst_cause_o == 2'd1));

  a_r8_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_cause_o != 2'd0) |=> (rst_cause_o != 2'd0));

  a_r5_shut_ignores_rtc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SHUT && !reset_pin_i && $stable(pin_i)) |=> (state_q == S_SHUT));

  a_r4_stby_ignores_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STBY && !reset_pin_i && !rtc_tick_i && $stable(pin_i)) |=> (state_q == S_STBY));

  a_r7_abort_no_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ENTER && irq_i && !reset_pin_i) |=> active_o);

  a_r2_req_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && req_valid_i && !irq_i && !rtc_tick_i && !reset_pin_i && $stable(pin_i))
      |=> (state_q == S_IDLE));
endmodule

bind lpm_seq lpm_seq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_q      (state_q),
  .reset_pin_i  (reset_pin_i),
  .req_valid_i  (req_valid_i),
  .irq_i        (irq_i),
  .rtc_tick_i   (rtc_tick_i),
  .pin_i        (pin_i),
  .active_o     (active_o),
  .sys_rst_o    (sys_rst_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .sram_ret_o   (sram_ret_o),
  .rst_cause_o  (rst_cause_o)
);

// File: tb/tb_lpm_seq.sv
`timescale 1ns/1ps
module tb_lpm_seq;
  localparam int unsigned MHZ = 1;
  localparam int unsigned ENT = 3;
  localparam int unsigned NP  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reset_pin = 1'b0, req_valid = 1'b0, irq = 1'b0, rtc = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [NP-1:0] pin = '0, pin_en = 4'b0011;
  logic [1:0] mode, bod, regret, cause;
  logic active, sysrst, cpu, flash, sram, radio, periph, hf, lf, por, latch;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lpm_seq #(.REF_CLK_MHZ(MHZ), .ENTRY_CYCLES(ENT), .NUM_PINS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reset_pin_i(reset_pin), .req_valid_i(req_valid),
    .req_mode_i(req_mode), .irq_i(irq), .rtc_tick_i(rtc), .pin_i(pin), .pin_wake_en_i(pin_en),
    .mode_o(mode), .active_o(active), .sys_rst_o(sysrst), .cpu_clk_en_o(cpu), .flash_en_o(flash),
    .sram_ret_o(sram), .radio_en_o(radio), .periph_en_o(periph), .hf_clk_en_o(hf),
    .lf_clk_en_o(lf), .bod_mode_o(bod), .por_en_o(por), .io_latch_o(latch),
    .reg_ret_o(regret), .rst_cause_o(cause)
  );

  function automatic int unsigned lat_of(int m);
    case (m)
      1: return 14 * MHZ;
      2: return 151 * MHZ;
      default: return 1015 * MHZ;
    endcase
  endfunction

  // {cpu,flash,sram,radio,periph,hf,lf,bod[1:0],latch,regret[1:0]}; 4 = reset-pin hold
  function automatic logic [11:0] exp_vec(int m);
    case (m)
      0: return 12'b1111111_10_0_10;
      1: return 12'b0111111_10_0_10;
      2: return 12'b0010001_01_1_01;
      3: return 12'b0000000_00_1_00;
      default: return 12'b0000000_00_0_00;
    endcase
  endfunction

  function automatic logic [11:0] vec();
    return {cpu, flash, sram, radio, periph, hf, lf, bod, latch, regret};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enter_mode(int m);
    @(negedge clk); req_valid = 1'b1; req_mode = 2'(m);
    @(negedge clk); req_valid = 1'b0;
    repeat (ENT) @(negedge clk);
  endtask

  // src: 0 irq, 1 rtc, 2 enabled pin, 3 masked pin
  task automatic fire(int src);
    case (src)
      0: irq = 1'b1;
      1: rtc = 1'b1;
      2: pin[0] = ~pin[0];
      default: pin[3] = ~pin[3];
    endcase
  endtask

  task automatic measure(output int unsigned lat, output logic first_rst);
    int unsigned n = 0;
    first_rst = 1'b0;
    do begin
      @(negedge clk);
      irq = 1'b0; rtc = 1'b0;
      n++;
      if (n == 1) first_rst = sysrst;
    end while (!active && n < 1200);
    lat = n - 1;
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int unsigned lat;
    logic frst;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", 32'(active), 1);
    chk("R1 mode", 32'(mode), 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 enables", 32'(vec()), 32'(exp_vec(0)));
    chk("R10 por active", 32'(por), 1);

    // mode x source sweep (R3 R4 R5 R9)
    for (int m = 1; m <= 3; m++) begin
      for (int src = 0; src <= 3; src++) begin
        bit ok;
        enter_mode(m);
        chk("R2 mode entered", 32'(mode), 32'(m));
        chk("R2 not active", 32'(active), 0);
        chk(m == 1 ? "R3 idle enables" : m == 2 ? "R4 standby enables" : "R5 shutdown enables",
            32'(vec()), 32'(exp_vec(m)));
        chk("R10 por in mode", 32'(por), 1);
        ok = (src == 2) || (m == 1 && src != 3) || (m == 2 && src == 1);
        fire(src);
        if (!ok) begin
          repeat (6) begin @(negedge clk); irq = 1'b0; rtc = 1'b0; end
          chk(src == 3 ? "R9 masked pin ignored" : m == 2 ? "R4 irq ignored" : "R5 source ignored",
              32'(mode), 32'(m));
          chk("R9/R4/R5 still asleep", 32'(active), 0);
          fire(2);
        end
        measure(lat, frst);
        chk(m == 1 ? "R3 idle latency" : m == 2 ? "R4 standby latency" : "R5 shutdown latency",
            lat, lat_of(m));
        chk("R5 reset during wake", 32'(frst), (m == 3) ? 1 : 0);
        chk("R1 running enables", 32'(vec()), 32'(exp_vec(0)));
        if (m == 3) chk("R5 cause shutdown wake", 32'(cause), 2);
      end
    end

    // R7 abort during entry, no latency
    for (int m = 1; m <= 3; m++) begin
      for (int src = 0; src <= 2; src++) begin
        @(negedge clk); req_valid = 1'b1; req_mode = 2'(m);
        @(negedge clk); req_valid = 1'b0;
        fire(src);
        @(negedge clk); irq = 1'b0; rtc = 1'b0;
        chk("R7 abort returns active", 32'(active), 1);
        chk("R7 abort mode", 32'(mode), 0);
      end
    end

    // R2 request while in IDLE ignored
    enter_mode(1);
    @(negedge clk); req_valid = 1'b1; req_mode = 2'd2;
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 request in idle ignored", 32'(mode), 1);
    fire(0);
    measure(lat, frst);
    chk("R3 idle latency after ignored req", lat, lat_of(1));

    // R6 reset pin from standby
    enter_mode(2);
    @(negedge clk); reset_pin = 1'b1;
    @(negedge clk);
    chk("R6 hold enables", 32'(vec()), 32'(exp_vec(4)));
    chk("R6 hold sys_rst", 32'(sysrst), 1);
    chk("R6 hold cause", 32'(cause), 1);
    chk("R10 por in hold", 32'(por), 1);
    repeat (3) @(negedge clk);
    reset_pin = 1'b0;
    measure(lat, frst);
    chk("R6 release latency", lat, lat_of(3));
    chk("R6 release sys_rst", 32'(frst), 1);

    // R8 cause persists through other activity
    enter_mode(1);
    fire(1);
    measure(lat, frst);
    chk("R8 cause sticky", 32'(cause), 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 cleared by por", 32'(cause), 0);
    chk("R1 active after por", 32'(active), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule